// File: doc/BRIEF.md
# Vector Length Control Register File

This block keeps the control state that a scalar core needs to run a hardware vector loop. The state is the largest vector length allowed, the length currently granted, the size of a sub-vector group, and the source, destination and sub-vector element offsets. All of it sits in one packed 32-bit word. That word can be read and written as a whole, and separate views of the maximum length, the current length and the group size can be read and written on their own. Every write is cleaned before it lands. A length outside its range is clamped to the nearest legal value rather than rejected. A group size outside 1 to 4 raises a flag and is dropped.

The block also runs the set-length operation. The core offers a requested length and, in the same cycle, gets back the length actually granted, which becomes the live current length at the next clock edge. For trap handling, each privilege level has its own saved copy of the state word. On trap entry or return, the live word and the saved word of the chosen level trade places in one cycle. The saved copies can also be read and written directly so that software can save and restore context.

Top module: `vlen_ctrl_regs`

## Requirements
- R1: After reset the live word and every saved word hold maximum length XLEN and current length 1 (both codes and all offsets as below), group size 1, and all offsets 0.
- R2: The packed word places the maximum-length code at bits 5:0, the current-length code at 11:6, the source offset at 17:12, the destination offset at 23:18, the group-size code at 25:24 and the sub-vector destination offset at 27:26. Length codes are biased by one (code 0 = length 1). The views (select 1 = maximum length, 2 = current length, 3 = group size) read and write decoded values, that is, code plus one. Select 0 is the whole live word and select 4 is the saved word of the level on `csr_lvl`.
- R3: A whole-word write clamps the maximum-length code to XLEN-1. It then truncates the current-length code to the new maximum-length code. The offsets and the group-size code are stored as written.
- R4: A set-length request with length n returns grant = min(max(n,1), current maximum length) in the same cycle, and the current length equals that grant after the next clock edge.
- R5: A write to the maximum-length view stores its value clamped to 1..XLEN. If the current length is then above the new maximum, the current length is lowered to it.
- R6: A write to the current-length view stores its value clamped to 1..current maximum length, so a value of 0 gives 1.
- R7: A write of 1..4 to the group-size view stores code value-1. Any other value raises `grp_illegal` in that cycle and leaves the group size unchanged.
- R8: Bits 31:28 of the live word and of every saved word always read as 0, whatever is written.
- R9: A swap request exchanges the live word and the saved word of level `priv_swap_lvl` in one clock edge. A second swap restores both.
- R10: Priority is swap, then set-length, then CSR write. A CSR write that arrives in the same cycle as a swap or a set-length request is dropped and flagged on `wr_dropped` in that cycle. A set-length request that coincides with a swap is dropped.
- R11: A write through select 4 stores into the saved word of level `csr_lvl`, cleaned by the same rules as R3 and R8, and leaves the live word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | CSR write strobe |
| csr_wr_sel | input | 3 | Write target: 0 word, 1 max length, 2 current length, 3 group size, 4 saved word |
| csr_wr_data | input | 32 | Write data |
| csr_lvl | input | LVL_W | Privilege level for select 4 reads and writes |
| csr_rd_sel | input | 3 | Read source, same encoding as write select |
| csr_rd_data | output | 32 | Read data (combinational) |
| vl_set_req | input | 1 | Set-length request |
| vl_set_len | input | 32 | Requested length |
| vl_set_grant | output | 7 | Granted length (combinational) |
| priv_swap | input | 1 | Swap live word with a saved word |
| priv_swap_lvl | input | LVL_W | Level whose saved word is swapped |
| grp_illegal | output | 1 | Illegal group-size write this cycle |
| wr_dropped | output | 1 | CSR write lost to a swap or set-length request this cycle |

## Verification
The bench runs with XLEN below 64 so that the clamping of the maximum length can be seen. A design that skipped that clamp would read back 64 instead of 48. The length edges are driven directly: requests of 0, exactly the maximum, and far above it. A design that handled 0 as a length would grant a length of zero, and one that forgot the truncation would leave the current length above the maximum after the maximum was lowered. Illegal group sizes of 0 and 5 are written to catch a design that masks the value to two bits and so stores a wrong size silently. Collisions are also driven, a swap against a word write and a set-length request against a view write, to catch wrong priority, a write that should have been dropped landing anyway, and a missing drop flag.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

    localparam int LEN_W = 6;

    typedef struct packed {
        logic [3:0]       rsvd;
        logic [1:0]       sub_dst_off;
        logic [1:0]       grp_code;
        logic [LEN_W-1:0] dst_off;
        logic [LEN_W-1:0] src_off;
        logic [LEN_W-1:0] cur_code;
        logic [LEN_W-1:0] max_code;
    } vstate_t;

    typedef enum logic [2:0] {
        SEL_WORD   = 3'd0,
        SEL_MAXLEN = 3'd1,
        SEL_CURLEN = 3'd2,
        SEL_GRPSZ  = 3'd3,
        SEL_SAVED  = 3'd4
    } csr_sel_e;

    // Clamp a requested length into 1..hi.
    function automatic logic [LEN_W:0] clamp_len(logic [31:0] req, logic [LEN_W:0] hi);
        if (req == 32'd0)
            return (LEN_W+1)'(1);
        else if (req > {{(31-LEN_W){1'b0}}, hi})
            return hi;
        else
            return req[LEN_W:0];
    endfunction

    // Clean a raw word: reserved zero, max within limit, cur within max.
    function automatic vstate_t sanitize(logic [31:0] raw, logic [LEN_W:0] lim);
        vstate_t s;
        s      = vstate_t'(raw);
        s.rsvd = 4'd0;
        if ({1'b0, s.max_code} > lim - 1'b1)
            s.max_code = LEN_W'(lim - 1'b1);
        if (s.cur_code > s.max_code)
            s.cur_code = s.max_code;
        return s;
    endfunction

    function automatic vstate_t reset_state(logic [LEN_W:0] lim);
        vstate_t s;
        s          = '0;
        s.max_code = LEN_W'(lim - 1'b1);
        return s;
    endfunction

endpackage

// File: rtl/vlc_setlen.sv
module vlc_setlen
    import vlc_pkg::*;
(
    input  logic [LEN_W-1:0] max_code,
    input  logic [31:0]      req_len,
    output logic [LEN_W:0]   grant
);
    logic [LEN_W:0] max_len;

    always_comb begin
        max_len = {1'b0, max_code} + 1'b1;
        grant   = clamp_len(req_len, max_len);
    end
endmodule

// File: rtl/vlc_save_bank.sv
module vlc_save_bank
    import vlc_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NLVL = 4,
    localparam int LVL_W = $clog2(NLVL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LVL_W-1:0] wr_lvl,
    input  vstate_t          wr_word,
    input  logic             swap_en,
    input  logic [LVL_W-1:0] swap_lvl,
    input  vstate_t          live_word,
    input  logic [LVL_W-1:0] rd_lvl,
    output vstate_t          rd_word,
    output vstate_t          swap_word
);
    localparam logic [LEN_W:0] LIM = (LEN_W+1)'(XLEN);

    vstate_t saved_q [NLVL];

    for (genvar k = 0; k < NLVL; k++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst)
                saved_q[k] <= reset_state(LIM);
            else if (swap_en && swap_lvl == LVL_W'(k))
                saved_q[k] <= live_word;
            else if (wr_en && wr_lvl == LVL_W'(k))
                saved_q[k] <= wr_word;
        end
    end

    always_comb begin
        rd_word   = saved_q[rd_lvl];
        swap_word = saved_q[swap_lvl];
    end
endmodule

// File: rtl/vlc_next_state.sv
module vlc_next_state
    import vlc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  vstate_t        live,
    input  vstate_t        swap_word,
    input  logic           swap_en,
    input  logic           set_req,
    input  logic [LEN_W:0] set_grant,
    input  logic           wr_en,
    input  logic [2:0]     wr_sel,
    input  logic [31:0]    wr_data,
    output vstate_t        nxt,
    output logic           illegal,
    output logic           lost,
    output logic           sv_we,
    output vstate_t        sv_word
);
    localparam logic [LEN_W:0] LIM = (LEN_W+1)'(XLEN);

    logic           grp_ok;
    logic [LEN_W:0] new_max;
    logic [LEN_W:0] new_cur;

    always_comb begin
        nxt     = live;
        illegal = 1'b0;
        lost    = 1'b0;
        sv_we   = 1'b0;
        sv_word = sanitize(wr_data, LIM);
        grp_ok  = (wr_data >= 32'd1) && (wr_data <= 32'd4);
        new_max = clamp_len(wr_data, LIM);
        new_cur = clamp_len(wr_data, {1'b0, live.max_code} + 1'b1);

        if (wr_en && wr_sel == SEL_GRPSZ && !grp_ok)
            illegal = 1'b1;

        if (swap_en) begin
            nxt  = swap_word;
            lost = wr_en;
        end else if (set_req) begin
            nxt.cur_code = LEN_W'(set_grant - 1'b1);
            lost         = wr_en;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_WORD:   nxt = sv_word;
                SEL_MAXLEN: begin
                    nxt.max_code = LEN_W'(new_max - 1'b1);
                    if (live.cur_code > nxt.max_code)
                        nxt.cur_code = nxt.max_code;
                end
                SEL_CURLEN: nxt.cur_code = LEN_W'(new_cur - 1'b1);
                SEL_GRPSZ:  if (grp_ok) nxt.grp_code = 2'(wr_data[1:0] - 2'd1);
                SEL_SAVED:  sv_we = 1'b1;
                default:    nxt = live;
            endcase
        end
    end
endmodule

// File: rtl/vlc_read_mux.sv
module vlc_read_mux
    import vlc_pkg::*;
(
    input  logic [2:0]  rd_sel,
    input  vstate_t     live,
    input  vstate_t     saved,
    output logic [31:0] rd_data
);
    always_comb begin
        case (rd_sel)
            SEL_WORD:   rd_data = live;
            SEL_MAXLEN: rd_data = 32'({1'b0, live.max_code} + 1'b1);
            SEL_CURLEN: rd_data = 32'({1'b0, live.cur_code} + 1'b1);
            SEL_GRPSZ:  rd_data = 32'({1'b0, live.grp_code} + 1'b1);
            SEL_SAVED:  rd_data = saved;
            default:    rd_data = 32'd0;
        endcase
    end
endmodule

// File: rtl/vlen_ctrl_regs.sv
module vlen_ctrl_regs
    import vlc_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NLVL = 4,
    localparam int LVL_W = $clog2(NLVL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_wr_en,
    input  logic [2:0]       csr_wr_sel,
    input  logic [31:0]      csr_wr_data,
    input  logic [LVL_W-1:0] csr_lvl,
    input  logic [2:0]       csr_rd_sel,
    output logic [31:0]      csr_rd_data,
    input  logic             vl_set_req,
    input  logic [31:0]      vl_set_len,
    output logic [6:0]       vl_set_grant,
    input  logic             priv_swap,
    input  logic [LVL_W-1:0] priv_swap_lvl,
    output logic             grp_illegal,
    output logic             wr_dropped
);
    localparam logic [LEN_W:0] LIM = (LEN_W+1)'(XLEN);

    vstate_t        live_q;
    vstate_t        live_d;
    vstate_t        swap_word;
    vstate_t        saved_rd;
    vstate_t        sv_word;
    logic           sv_we;
    logic [LEN_W:0] grant;

    vlc_setlen u_setlen (
        .max_code (live_q.max_code),
        .req_len  (vl_set_len),
        .grant    (grant)
    );

    vlc_next_state #(.XLEN(XLEN)) u_next (
        .live      (live_q),
        .swap_word (swap_word),
        .swap_en   (priv_swap),
        .set_req   (vl_set_req),
        .set_grant (grant),
        .wr_en     (csr_wr_en),
        .wr_sel    (csr_wr_sel),
        .wr_data   (csr_wr_data),
        .nxt       (live_d),
        .illegal   (grp_illegal),
        .lost      (wr_dropped),
        .sv_we     (sv_we),
        .sv_word   (sv_word)
    );

    vlc_save_bank #(.XLEN(XLEN), .NLVL(NLVL)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (sv_we),
        .wr_lvl    (csr_lvl),
        .wr_word   (sv_word),
        .swap_en   (priv_swap),
        .swap_lvl  (priv_swap_lvl),
        .live_word (live_q),
        .rd_lvl    (csr_lvl),
        .rd_word   (saved_rd),
        .swap_word (swap_word)
    );

    vlc_read_mux u_rd (
        .rd_sel  (csr_rd_sel),
        .live    (live_q),
        .saved   (saved_rd),
        .rd_data (csr_rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst)
            live_q <= reset_state(LIM);
        else
            live_q <= live_d;
    end

    assign vl_set_grant = 7'(grant);
endmodule

// File: rtl/vlc_checker.sv
module vlc_checker #(
    parameter int XLEN = 64
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] live_q,
    input logic [31:0] swap_word,
    input logic        csr_wr_en,
    input logic        vl_set_req,
    input logic [6:0]  vl_set_grant,
    input logic        priv_swap,
    input logic        grp_illegal,
    input logic        wr_dropped
);
    p_cur_le_max_r3: assert property (@(posedge clk) disable iff (rst)
        live_q[11:6] <= live_q[5:0]);

    p_max_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        {1'b0, live_q[5:0]} <= 7'(XLEN - 1));

    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (rst)
        live_q[31:28] == 4'd0);

    p_grp_hold_r7: assert property (@(posedge clk) disable iff (rst)
        grp_illegal && !priv_swap |=> $stable(live_q[25:24]));

    p_swap_load_r9: assert property (@(posedge clk) disable iff (rst)
        priv_swap |=> live_q == $past(swap_word));

    p_grant_lands_r4: assert property (@(posedge clk) disable iff (rst)
        vl_set_req && !priv_swap |=> live_q[11:6] == 6'($past(vl_set_grant) - 7'd1));

    p_grant_min_r4: assert property (@(posedge clk) disable iff (rst)
        vl_set_req |-> vl_set_grant >= 7'd1);

    p_drop_cause_r10: assert property (@(posedge clk) disable iff (rst)
        wr_dropped |-> csr_wr_en && (priv_swap || vl_set_req));
endmodule

bind vlen_ctrl_regs vlc_checker #(.XLEN(XLEN)) u_vlc_checker (
    .clk          (clk),
    .rst          (rst),
    .live_q       (live_q),
    .swap_word    (swap_word),
    .csr_wr_en    (csr_wr_en),
    .vl_set_req   (vl_set_req),
    .vl_set_grant (vl_set_grant),
    .priv_swap    (priv_swap),
    .grp_illegal  (grp_illegal),
    .wr_dropped   (wr_dropped)
);

// File: tb/test_vlen_ctrl_regs.sv
module test_vlen_ctrl_regs;
    localparam int XL = 48;
    localparam int NL = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        csr_wr_en;
    logic [2:0]  csr_wr_sel;
    logic [31:0] csr_wr_data;
    logic [1:0]  csr_lvl;
    logic [2:0]  csr_rd_sel;
    logic [31:0] csr_rd_data;
    logic        vl_set_req;
    logic [31:0] vl_set_len;
    logic [6:0]  vl_set_grant;
    logic        priv_swap;
    logic [1:0]  priv_swap_lvl;
    logic        grp_illegal;
    logic        wr_dropped;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic       g_ill, g_lost;
    logic [6:0] g_grant;

    always #4 clk = ~clk;

    vlen_ctrl_regs #(.XLEN(XL), .NLVL(NL)) i_vlen_ctrl_regs (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic idle();
        csr_wr_en = 0; csr_wr_sel = 0; csr_wr_data = 0; csr_lvl = 0;
        vl_set_req = 0; vl_set_len = 0; priv_swap = 0; priv_swap_lvl = 0;
    endtask

    // One cycle of stimulus; same-cycle outputs captured before the edge.
    task automatic step(input logic we, input logic [2:0] sel, input logic [31:0] d,
                        input logic [1:0] lvl, input logic sr, input logic [31:0] n,
                        input logic sw, input logic [1:0] swl);
        @(negedge clk);
        csr_wr_en = we; csr_wr_sel = sel; csr_wr_data = d; csr_lvl = lvl;
        vl_set_req = sr; vl_set_len = n; priv_swap = sw; priv_swap_lvl = swl;
        #1;
        g_ill = grp_illegal; g_lost = wr_dropped; g_grant = vl_set_grant;
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d, input logic [1:0] lvl = 0);
        step(1, sel, d, lvl, 0, 0, 0, 0);
    endtask

    task automatic rd(input logic [2:0] sel, input logic [1:0] lvl, output logic [31:0] v);
        csr_rd_sel = sel; csr_lvl = lvl;
        #1;
        v = csr_rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, 0, v); chk("R1 word", v, 32'h0000_002F);
        rd(1, 0, v); chk("R1 maxlen", v, 48);
        rd(2, 0, v); chk("R1 curlen", v, 1);
        rd(3, 0, v); chk("R1 grpsz", v, 1);
        rd(4, 3, v); chk("R1 saved3", v, 32'h0000_002F);
    endtask

    task automatic t_word();
        logic [31:0] v;
        wr(0, 32'hFFFF_FFFF);
        rd(0, 0, v); chk("R3 R8 clamp all-ones", v, 32'h0FFF_FBEF);
        rd(2, 0, v); chk("R2 curlen decoded", v, 48);
        rd(3, 0, v); chk("R2 grpsz decoded", v, 4);
        wr(0, 32'h0000_0509);
        rd(0, 0, v); chk("R3 cur truncated to max", v, 32'h0000_0249);
        rd(1, 0, v); chk("R2 maxlen view", v, 10);
        wr(0, 32'hF000_0000);
        rd(0, 0, v); chk("R8 reserved zero", v, 32'h0000_0000);
        rd(1, 0, v); chk("R2 code0 is len1", v, 1);
    endtask

    task automatic t_setlen();
        logic [31:0] v;
        wr(0, 32'h0000_0249);
        step(0, 0, 0, 0, 1, 7, 0, 0);
        chk("R4 grant 7", 32'(g_grant), 7);
        rd(2, 0, v); chk("R4 vl 7", v, 7);
        step(0, 0, 0, 0, 1, 100, 0, 0);
        chk("R4 grant clipped", 32'(g_grant), 10);
        rd(2, 0, v); chk("R4 vl 10", v, 10);
        step(0, 0, 0, 0, 1, 0, 0, 0);
        chk("R4 grant zero->1", 32'(g_grant), 1);
        rd(2, 0, v); chk("R4 vl 1", v, 1);
        step(0, 0, 0, 0, 1, 10, 0, 0);
        chk("R4 grant equal max", 32'(g_grant), 10);
    endtask

    task automatic t_maxview();
        logic [31:0] v;
        wr(2, 10);
        wr(1, 4);
        rd(1, 0, v); chk("R5 max 4", v, 4);
        rd(2, 0, v); chk("R5 cur lowered", v, 4);
        wr(1, 200);
        rd(1, 0, v); chk("R5 max clamp XLEN", v, 48);
        rd(2, 0, v); chk("R5 cur kept", v, 4);
        wr(1, 0);
        rd(1, 0, v); chk("R5 max 0->1", v, 1);
        rd(2, 0, v); chk("R5 cur at 1", v, 1);
    endtask

    task automatic t_curview();
        logic [31:0] v;
        wr(1, 48);
        wr(2, 0);  rd(2, 0, v); chk("R6 cur 0->1", v, 1);
        wr(2, 30); rd(2, 0, v); chk("R6 cur 30", v, 30);
        wr(2, 60); rd(2, 0, v); chk("R6 cur clamp max", v, 48);
    endtask

    task automatic t_grp();
        logic [31:0] v;
        wr(3, 3);
        chk("R7 legal no flag", 32'(g_ill), 0);
        rd(3, 0, v); chk("R7 grp 3", v, 3);
        rd(0, 0, v); chk("R7 code bits 25:24", 32'(v[25:24]), 2);
        wr(3, 5);
        chk("R7 flag on 5", 32'(g_ill), 1);
        rd(3, 0, v); chk("R7 unchanged after 5", v, 3);
        wr(3, 0);
        chk("R7 flag on 0", 32'(g_ill), 1);
        rd(3, 0, v); chk("R7 unchanged after 0", v, 3);
        wr(3, 4);
        rd(3, 0, v); chk("R7 grp 4", v, 4);
    endtask

    task automatic t_saved_swap();
        logic [31:0] v;
        wr(0, 32'h0000_0249);
        wr(4, 32'h0100_0145, 2);
        rd(0, 0, v); chk("R11 live untouched", v, 32'h0000_0249);
        rd(4, 2, v); chk("R11 saved2 written", v, 32'h0100_0145);
        wr(4, 32'hFFFF_FFFF, 1);
        rd(4, 1, v); chk("R11 saved1 cleaned", v, 32'h0FFF_FBEF);
        step(0, 0, 0, 0, 0, 0, 1, 2);
        rd(0, 0, v); chk("R9 live after swap", v, 32'h0100_0145);
        rd(4, 2, v); chk("R9 saved after swap", v, 32'h0000_0249);
        step(0, 0, 0, 0, 0, 0, 1, 2);
        rd(0, 0, v); chk("R9 live restored", v, 32'h0000_0249);
        rd(4, 2, v); chk("R9 saved restored", v, 32'h0100_0145);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        wr(0, 32'h0000_0249);
        wr(4, 32'h0000_0145, 3);
        step(1, 0, 32'h0000_0000, 0, 0, 0, 1, 3);
        chk("R10 drop flag on swap", 32'(g_lost), 1);
        rd(0, 0, v); chk("R10 swap wins", v, 32'h0000_0145);
        rd(4, 3, v); chk("R10 saved got live", v, 32'h0000_0249);
        step(1, 2, 5, 0, 1, 3, 0, 0);
        chk("R10 drop flag on setlen", 32'(g_lost), 1);
        rd(2, 0, v); chk("R10 setlen wins", v, 3);
        wr(2, 5);
        chk("R10 no drop alone", 32'(g_lost), 0);
        rd(2, 0, v); chk("R10 lone write lands", v, 5);
    endtask

    initial begin
        idle();
        csr_rd_sel = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_word();
        t_setlen();
        t_maxview();
        t_curview();
        t_grp();
        t_saved_swap();
        t_priority();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule